// File: doc/BRIEF.md
# Banked Multiport Register File with Forwarding

This block is the architectural register store of a wide-issue fixed-point core. It holds thirty-two 32-bit registers behind thirteen read ports and nine write ports. Reads are combinational from the address. Writes commit on the rising clock edge. A read that names a register being written in the same cycle returns the incoming data rather than the stored value.

Storage is divided into an even bank and an odd bank of sixteen rows each. Three read ports and three write ports can each be switched to long mode. In that mode the port moves a 64-bit operand held in an even/odd register pair, and one row address drives both banks. The high word of a long access travels on a companion port (read 10–12, write 6–8) whose own address is then ignored. Because the companion shares its partner's array slot, each bank needs only ten read slots and six write slots.

A test mode hands one chosen write port's address, enable and data to dedicated inputs and disables every other write. It also routes a chosen read port onto a single observation output.

Top module: `mp_regfile`

## Requirements
- R1: After synchronous reset, every register reads as zero on every read port.
- R2: A short write through any write port with enable high stores its data at the rising edge. Any read port naming that register returns the data from the next cycle on.
- R3: A read naming a register that an enabled write targets in the same cycle returns the write data combinationally. The value read is unchanged in the following cycle when no new write occurs.
- R4: When several enabled writes target one register in a cycle, the highest-numbered port's data is stored and forwarded. The high word of a long write counts as its partner port's number.
- R5: Read port i (i = 0..2) in long mode returns the even register of the addressed pair on port i and the odd register on read port 10+i. Port 10+i's own address has no effect.
- R6: Write port i (i = 0..2) in long mode, when enabled, writes its data to the even register and write port 6+i's data to the odd register. Port 6+i's address and enable have no effect.
- R7: In long mode, address bit 0 is ignored, so an odd address selects the pair starting at the even register below it.
- R8: A short companion port shares its partner's slot, and address bit 0 selects the bank. A companion read whose bank equals its short partner's bank returns zero. A companion write whose bank equals its enabled short partner's bank is dropped and not forwarded. Otherwise both work normally.
- R9: With test mode high, the selected write port (index on the test select input) takes the test address, enable and data as a short write. All other write ports and all long write flags are ignored.
- R10: With test mode high, the observation output equals the selected read port's data, including forwarded data. With test mode low it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | NRD*AW (65) | Read addresses, port p at bits p*AW +: AW |
| rd_long | input | NLONG (3) | Long mode for read ports 0..2 |
| rd_data | output | NRD*DW (416) | Read data, port p at bits p*DW +: DW |
| wr_en | input | NWR (9) | Write enables per port |
| wr_addr | input | NWR*AW (45) | Write addresses, port p at bits p*AW +: AW |
| wr_data | input | NWR*DW (288) | Write data, port p at bits p*DW +: DW |
| wr_long | input | NLONG (3) | Long mode for write ports 0..2 |
| tm_en | input | 1 | Test mode |
| tm_wsel | input | PW (4) | Write port taken over in test mode |
| tm_we | input | 1 | Test write enable |
| tm_addr | input | AW (5) | Test write address |
| tm_data | input | DW (32) | Test write data |
| tm_rsel | input | RPW (4) | Read port routed to the observation output |
| tm_obs | output | DW (32) | Observation output |

## Verification
A wrong winner in a bank's priority compare stores a lower port's data. The bad word appears on the forwarded read in the same cycle and on every later read of that register. A mis-steered slot shows up at once as a companion read of zero, or as a pair whose halves are swapped. A dropped companion write that leaks through shows as a nonzero value one cycle later at a register that should still hold zero. A stuck row would return stale data on the first read after the commit edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NBANK = 2;
  typedef enum logic {BANK_EVEN = 1'b0, BANK_ODD = 1'b1} bank_e;
endpackage

// File: rtl/rf_wr_steer.sv
module rf_wr_steer
  import rf_pkg::*;
#(
  parameter int NWR   = 9,
  parameter int NLONG = 3,
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int PW    = 4,
  parameter int NWS   = NWR - NLONG,
  parameter int RW    = AW - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NWR-1:0]      wr_en,
  input  logic [NWR*AW-1:0]   wr_addr,
  input  logic [NWR*DW-1:0]   wr_data,
  input  logic [NLONG-1:0]    wr_long,
  input  logic                tm_en,
  input  logic [PW-1:0]       tm_wsel,
  input  logic                tm_we,
  input  logic [AW-1:0]       tm_addr,
  input  logic [DW-1:0]       tm_data,
  output logic [NWS-1:0]      s_en  [NBANK],
  output logic [RW-1:0]       s_row [NBANK][NWS],
  output logic [DW-1:0]       s_data[NBANK][NWS],
  output logic [PW-1:0]       s_pri [NBANK][NWS]
);
  logic [NWR-1:0]   e_en;
  logic [AW-1:0]    e_addr [NWR];
  logic [DW-1:0]    e_data [NWR];
  logic [NLONG-1:0] e_long;

  // test mode takes over one port and silences the rest
  always_comb begin
    for (int p = 0; p < NWR; p++) begin
      e_en[p]   = wr_en[p] & ~tm_en;
      e_addr[p] = wr_addr[p*AW +: AW];
      e_data[p] = wr_data[p*DW +: DW];
      if (tm_en && tm_wsel == PW'(p)) begin
        e_en[p]   = tm_we;
        e_addr[p] = tm_addr;
        e_data[p] = tm_data;
      end
    end
  end
  assign e_long = wr_long & {NLONG{~tm_en}};

  for (genvar s = 0; s < NWS; s++) begin : g_slot
    logic          en_e, en_o;
    logic [RW-1:0] row_e, row_o;
    logic [DW-1:0] dat_e, dat_o;
    logic [PW-1:0] pri_e, pri_o;

    if (s < NLONG) begin : g_pair
      localparam int C = NWS + s;
      always_comb begin
        en_e = 1'b0; en_o = 1'b0; row_e = '0; row_o = '0;
        dat_e = '0; dat_o = '0; pri_e = '0; pri_o = '0;
        if (e_long[s]) begin
          if (e_en[s]) begin
            en_e  = 1'b1;             en_o  = 1'b1;
            row_e = e_addr[s][AW-1:1]; row_o = e_addr[s][AW-1:1];
            dat_e = e_data[s];         dat_o = e_data[C];
            pri_e = PW'(s);            pri_o = PW'(s);
          end
        end else begin
          if (e_en[s]) begin
            if (e_addr[s][0]) begin
              en_o = 1'b1; row_o = e_addr[s][AW-1:1]; dat_o = e_data[s]; pri_o = PW'(s);
            end else begin
              en_e = 1'b1; row_e = e_addr[s][AW-1:1]; dat_e = e_data[s]; pri_e = PW'(s);
            end
          end
          if (e_en[C] && !(e_en[s] && e_addr[C][0] == e_addr[s][0])) begin
            if (e_addr[C][0]) begin
              en_o = 1'b1; row_o = e_addr[C][AW-1:1]; dat_o = e_data[C]; pri_o = PW'(C);
            end else begin
              en_e = 1'b1; row_e = e_addr[C][AW-1:1]; dat_e = e_data[C]; pri_e = PW'(C);
            end
          end
        end
      end

      // R6: an enabled long write claims the same row in both banks
      p_long_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (e_long[s] && e_en[s]) |-> (s_en[0][s] && s_en[1][s] && s_row[0][s] == s_row[1][s]));

      // R8: a companion colliding with its partner's bank is never granted
      p_comp_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (!tm_en && !wr_long[s] && wr_en[s] && wr_en[C] &&
         wr_addr[C*AW] == wr_addr[s*AW])
        |-> (!(s_en[0][s] && s_pri[0][s] == PW'(C)) &&
             !(s_en[1][s] && s_pri[1][s] == PW'(C))));
    end else begin : g_plain
      always_comb begin
        en_e = 1'b0; en_o = 1'b0; row_e = '0; row_o = '0;
        dat_e = '0; dat_o = '0; pri_e = PW'(s); pri_o = PW'(s);
        if (e_en[s]) begin
          if (e_addr[s][0]) begin
            en_o = 1'b1; row_o = e_addr[s][AW-1:1]; dat_o = e_data[s];
          end else begin
            en_e = 1'b1; row_e = e_addr[s][AW-1:1]; dat_e = e_data[s];
          end
        end
      end
    end

    assign s_en[BANK_EVEN][s]   = en_e;
    assign s_en[BANK_ODD][s]    = en_o;
    assign s_row[BANK_EVEN][s]  = row_e;
    assign s_row[BANK_ODD][s]   = row_o;
    assign s_data[BANK_EVEN][s] = dat_e;
    assign s_data[BANK_ODD][s]  = dat_o;
    assign s_pri[BANK_EVEN][s]  = pri_e;
    assign s_pri[BANK_ODD][s]   = pri_o;
  end

  // R9: in test mode at most one array slot is written
  p_tm_single_r9: assert property (@(posedge clk) disable iff (rst)
    tm_en |-> ($countones(s_en[0]) + $countones(s_en[1])) <= 1);
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int ROWS = 16,
  parameter int DW   = 32,
  parameter int NWS  = 6,
  parameter int NRS  = 10,
  parameter int PW   = 4,
  parameter int RW   = $clog2(ROWS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NWS-1:0] ws_en,
  input  logic [RW-1:0]  ws_row [NWS],
  input  logic [DW-1:0]  ws_data[NWS],
  input  logic [PW-1:0]  ws_pri [NWS],
  input  logic [RW-1:0]  rs_row [NRS],
  output logic [DW-1:0]  rs_data[NRS]
);
  logic [DW-1:0]   mem   [ROWS];
  logic [ROWS-1:0] hit;
  logic [DW-1:0]   val   [ROWS];
  logic [PW-1:0]   best  [ROWS];
  logic [NRS-1:0]  rs_fwd;
  logic            all_zero;

  // per row: keep the enabled slot with the highest port number
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      hit[r] = 1'b0; val[r] = '0; best[r] = '0;
      for (int s = 0; s < NWS; s++) begin
        if (ws_en[s] && ws_row[s] == RW'(r) && (!hit[r] || ws_pri[s] > best[r])) begin
          hit[r]  = 1'b1;
          val[r]  = ws_data[s];
          best[r] = ws_pri[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) if (hit[r]) mem[r] <= val[r];
    end
  end

  for (genvar s = 0; s < NRS; s++) begin : g_rd
    assign rs_fwd[s]  = hit[rs_row[s]];
    assign rs_data[s] = rs_fwd[s] ? val[rs_row[s]] : mem[rs_row[s]];

    // R3: a forwarded value is the one the row holds after the edge
    p_fwd_persist_r3: assert property (@(posedge clk) disable iff (rst)
      rs_fwd[s] ##1 (rs_row[s] == $past(rs_row[s]) && !rs_fwd[s])
      |-> rs_data[s] == $past(rs_data[s]));
  end

  always_comb begin
    all_zero = 1'b1;
    for (int r = 0; r < ROWS; r++) if (mem[r] != '0) all_zero = 1'b0;
  end

  // R1: reset leaves every row cleared
  p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> all_zero);
endmodule

// File: rtl/rf_rd_steer.sv
module rf_rd_steer
  import rf_pkg::*;
#(
  parameter int NRD   = 13,
  parameter int NLONG = 3,
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int NRS   = NRD - NLONG,
  parameter int RW    = AW - 1
) (
  input  logic [NRD*AW-1:0] rd_addr,
  input  logic [NLONG-1:0]  rd_long,
  output logic [RW-1:0]     rs_row [NBANK][NRS],
  input  logic [DW-1:0]     rs_q   [NBANK][NRS],
  output logic [NRD*DW-1:0] rd_data
);
  for (genvar s = 0; s < NRS; s++) begin : g_slot
    logic [AW-1:0] a_s;
    logic [RW-1:0] row_e, row_o;
    logic [DW-1:0] o_s;
    assign a_s = rd_addr[s*AW +: AW];

    if (s < NLONG) begin : g_pair
      localparam int C = NRS + s;
      logic [AW-1:0] a_c;
      logic [DW-1:0] o_c;
      assign a_c = rd_addr[C*AW +: AW];

      always_comb begin
        row_e = '0; row_o = '0;
        if (rd_long[s]) begin
          row_e = a_s[AW-1:1]; row_o = a_s[AW-1:1];
        end else begin
          if (a_s[0]) row_o = a_s[AW-1:1];
          else        row_e = a_s[AW-1:1];
          if (a_c[0] != a_s[0]) begin
            if (a_c[0]) row_o = a_c[AW-1:1];
            else        row_e = a_c[AW-1:1];
          end
        end
      end

      always_comb begin
        o_c = '0;
        if (rd_long[s]) begin
          o_s = rs_q[BANK_EVEN][s];
          o_c = rs_q[BANK_ODD][s];
        end else begin
          o_s = a_s[0] ? rs_q[BANK_ODD][s] : rs_q[BANK_EVEN][s];
          if (a_c[0] != a_s[0])
            o_c = a_c[0] ? rs_q[BANK_ODD][s] : rs_q[BANK_EVEN][s];
        end
      end
      assign rd_data[C*DW +: DW] = o_c;
    end else begin : g_plain
      assign row_e = a_s[AW-1:1];
      assign row_o = a_s[AW-1:1];
      assign o_s   = a_s[0] ? rs_q[BANK_ODD][s] : rs_q[BANK_EVEN][s];
    end

    assign rs_row[BANK_EVEN][s] = row_e;
    assign rs_row[BANK_ODD][s]  = row_o;
    assign rd_data[s*DW +: DW]  = o_s;
  end
endmodule

// File: rtl/mp_regfile.sv
module mp_regfile
  import rf_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int DW    = 32,
  parameter int NRD   = 13,
  parameter int NWR   = 9,
  parameter int NLONG = 3,
  parameter int AW    = $clog2(NREG),
  parameter int PW    = $clog2(NWR),
  parameter int RPW   = $clog2(NRD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRD*AW-1:0] rd_addr,
  input  logic [NLONG-1:0]  rd_long,
  output logic [NRD*DW-1:0] rd_data,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*DW-1:0] wr_data,
  input  logic [NLONG-1:0]  wr_long,
  input  logic              tm_en,
  input  logic [PW-1:0]     tm_wsel,
  input  logic              tm_we,
  input  logic [AW-1:0]     tm_addr,
  input  logic [DW-1:0]     tm_data,
  input  logic [RPW-1:0]    tm_rsel,
  output logic [DW-1:0]     tm_obs
);
  localparam int RW   = AW - 1;
  localparam int ROWS = NREG / NBANK;
  localparam int NRS  = NRD - NLONG;
  localparam int NWS  = NWR - NLONG;

  logic [NWS-1:0] s_en  [NBANK];
  logic [RW-1:0]  s_row [NBANK][NWS];
  logic [DW-1:0]  s_data[NBANK][NWS];
  logic [PW-1:0]  s_pri [NBANK][NWS];
  logic [RW-1:0]  rs_row[NBANK][NRS];
  logic [DW-1:0]  rs_q  [NBANK][NRS];

  rf_wr_steer #(.NWR(NWR), .NLONG(NLONG), .AW(AW), .DW(DW), .PW(PW),
                .NWS(NWS), .RW(RW)) u_wsteer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_long(wr_long), .tm_en(tm_en), .tm_wsel(tm_wsel), .tm_we(tm_we),
    .tm_addr(tm_addr), .tm_data(tm_data), .s_en(s_en), .s_row(s_row),
    .s_data(s_data), .s_pri(s_pri));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rf_bank #(.ROWS(ROWS), .DW(DW), .NWS(NWS), .NRS(NRS), .PW(PW), .RW(RW)) u_bank (
      .clk(clk), .rst(rst), .ws_en(s_en[b]), .ws_row(s_row[b]),
      .ws_data(s_data[b]), .ws_pri(s_pri[b]), .rs_row(rs_row[b]),
      .rs_data(rs_q[b]));
  end

  rf_rd_steer #(.NRD(NRD), .NLONG(NLONG), .AW(AW), .DW(DW), .NRS(NRS),
                .RW(RW)) u_rsteer (
    .rd_addr(rd_addr), .rd_long(rd_long), .rs_row(rs_row), .rs_q(rs_q),
    .rd_data(rd_data));

  always_comb begin
    tm_obs = '0;
    if (tm_en)
      for (int p = 0; p < NRD; p++)
        if (tm_rsel == RPW'(p)) tm_obs = rd_data[p*DW +: DW];
  end
endmodule

// File: tb/test_mp_regfile.sv
`timescale 1ns/1ps
module test_mp_regfile;
  localparam int DW = 32, AW = 5, NRD = 13, NWR = 9, NL = 3;
  localparam int OBS = 99;

  logic clk = 1'b0, rst = 1'b1;
  logic [NRD*AW-1:0] rd_addr;
  logic [NL-1:0]     rd_long;
  logic [NRD*DW-1:0] rd_data;
  logic [NWR-1:0]    wr_en;
  logic [NWR*AW-1:0] wr_addr;
  logic [NWR*DW-1:0] wr_data;
  logic [NL-1:0]     wr_long;
  logic tm_en, tm_we;
  logic [3:0] tm_wsel, tm_rsel;
  logic [AW-1:0] tm_addr;
  logic [DW-1:0] tm_data, tm_obs;

  mp_regfile i_mp_regfile (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_long(rd_long), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_long(wr_long),
    .tm_en(tm_en), .tm_wsel(tm_wsel), .tm_we(tm_we), .tm_addr(tm_addr),
    .tm_data(tm_data), .tm_rsel(tm_rsel), .tm_obs(tm_obs));

  always #5 clk = ~clk;

  typedef struct { int port; logic [DW-1:0] val; string tag; } item_t;
  item_t sb[$];
  event smp;
  int total = 0, bad = 0;
  bit finished = 0;

  // monitor: pops every expected item at the sample point
  initial forever begin
    @(smp);
    while (sb.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it = sb.pop_front();
      act = (it.port == OBS) ? tm_obs : rd_data[it.port*DW +: DW];
      total++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s port %0d actual=%h expected=%h", it.tag, it.port, act, it.val);
      end
    end
  end

  task automatic clr();
    rd_addr = '0; rd_long = '0; wr_en = '0; wr_addr = '0; wr_data = '0; wr_long = '0;
    tm_en = 0; tm_we = 0; tm_wsel = '0; tm_rsel = '0; tm_addr = '0; tm_data = '0;
  endtask
  task automatic setw(int p, int a, logic [DW-1:0] d);
    wr_en[p] = 1'b1; wr_addr[p*AW +: AW] = AW'(a); wr_data[p*DW +: DW] = d;
  endtask
  task automatic setr(int p, int a);
    rd_addr[p*AW +: AW] = AW'(a);
  endtask
  task automatic expect_v(int p, logic [DW-1:0] v, string tag);
    item_t it;
    it.port = p; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask
  task automatic tick();
    #2; ->smp; #1;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: all zero after reset
    for (int p = 0; p < NRD; p++) begin setr(p, 31 - 2*p); expect_v(p, '0, "R1"); end
    tick();
    // R2: short writes on ports 3..8 to regs 10..15
    clr();
    for (int p = 3; p < NWR; p++) setw(p, p + 7, 32'h1000_0000 + (p + 7));
    tick();
    clr();
    for (int p = 0; p < 6; p++) begin setr(p, 10 + p); expect_v(p, 32'h1000_000A + p, "R2"); end
    tick();
    // R3: same-cycle forwarding then persistence
    clr(); setw(4, 20, 32'hA5A5_0020); setr(9, 20); expect_v(9, 32'hA5A5_0020, "R3");
    tick();
    clr(); setr(9, 20); expect_v(9, 32'hA5A5_0020, "R3");
    tick();
    // R4: highest port wins
    clr(); setw(2, 21, 32'h2222_2222); setw(5, 21, 32'h5555_5555);
    setr(9, 21); expect_v(9, 32'h5555_5555, "R4");
    tick();
    clr(); setr(8, 21); expect_v(8, 32'h5555_5555, "R4");
    setw(3, 19, 32'h3333_3333); setw(8, 19, 32'h8888_8888);
    setr(9, 19); expect_v(9, 32'h8888_8888, "R4");
    tick();
    clr(); setr(7, 19); expect_v(7, 32'h8888_8888, "R4");
    tick();
    // R6/R7: long write on port 1, odd address, companion 7
    clr(); wr_long[1] = 1'b1; setw(1, 9, 32'hCAFE_0008);
    wr_addr[7*AW +: AW] = 5'd30; wr_data[7*DW +: DW] = 32'hBEEF_0009;
    setr(3, 8); setr(4, 9);
    expect_v(3, 32'hCAFE_0008, "R6"); expect_v(4, 32'hBEEF_0009, "R7");
    tick();
    clr(); setr(5, 30); setr(3, 8); setr(4, 9);
    expect_v(5, '0, "R6"); expect_v(3, 32'hCAFE_0008, "R6"); expect_v(4, 32'hBEEF_0009, "R6");
    tick();
    // R5/R7: long reads
    clr(); rd_long = 3'b101; setr(2, 8); setr(12, 31); setr(0, 15); setr(10, 4);
    expect_v(2, 32'hCAFE_0008, "R5"); expect_v(12, 32'hBEEF_0009, "R5");
    expect_v(0, 32'h1000_000E, "R7"); expect_v(10, 32'h1000_000F, "R7");
    tick();
    // R8: companion read sharing
    clr(); setr(0, 12); setr(10, 10); setr(1, 12); setr(11, 11);
    expect_v(0, 32'h1000_000C, "R8"); expect_v(10, '0, "R8");
    expect_v(1, 32'h1000_000C, "R8"); expect_v(11, 32'h1000_000B, "R8");
    tick();
    // R8: companion write sharing
    clr(); setw(0, 22, 32'h22); setw(6, 24, 32'h24); setw(1, 26, 32'h26); setw(7, 25, 32'h25);
    setr(9, 24); expect_v(9, '0, "R8");
    tick();
    clr(); setr(3, 22); setr(4, 24); setr(5, 25); setr(9, 26);
    expect_v(3, 32'h22, "R8"); expect_v(4, '0, "R8"); expect_v(5, 32'h25, "R8"); expect_v(9, 32'h26, "R8");
    tick();
    // R9/R10: test mode forced write, observed with forwarding
    clr(); tm_en = 1; tm_wsel = 4'd8; tm_we = 1; tm_addr = 5'd17; tm_data = 32'h7E57_0017;
    setw(3, 18, 32'h0000_0BAD); tm_rsel = 4'd5; setr(5, 17);
    expect_v(OBS, 32'h7E57_0017, "R10");
    tick();
    clr(); tm_en = 1; tm_rsel = 4'd6; setr(6, 18); setr(5, 17);
    expect_v(OBS, '0, "R9"); expect_v(5, 32'h7E57_0017, "R9");
    tick();
    clr(); tm_en = 1; tm_wsel = 4'd0; tm_we = 1; tm_addr = 5'd3; tm_data = 32'h7E57_0003;
    wr_long[0] = 1'b1; wr_data[6*DW +: DW] = 32'h0000_0BAD;
    tick();
    clr(); setr(3, 2); setr(4, 3);
    expect_v(3, '0, "R9"); expect_v(4, 32'h7E57_0003, "R9");
    tm_rsel = 4'd4; expect_v(OBS, '0, "R10");
    tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule